// File: doc/BRIEF.md
# Byte-Stretching Two-Wire Slave Engine

This block is the slave side of a two-wire open-drain serial bus (clock line and data line, both pulled up, only ever pulled low). It watches the bus for Start and Stop, shifts in a 7-bit address plus a direction bit, and answers only its own fixed address. Every byte travels in a 9-pulse frame. The data bits go most-significant first. The ninth pulse carries the acknowledge bit from whichever side received the byte.

After each acknowledged byte the engine holds the clock line low and raises a byte-complete interrupt. The clock stays held until host logic services the byte. In receive mode the host reads `rx_data`. In transmit mode it places the next byte on `tx_data`. In both cases it then pulses `release_i`. The master therefore cannot move on until the host has kept up. Both bus outputs are pull-down enables: a 1 pulls the line low and a 0 releases it.

The FSM has these states:
- `ST_IDLE`: bus free.
- `ST_ADDR`: shifting in the address byte.
- `ST_ADDR_END`: address complete, waiting for the clock to fall.
- `ST_ACK_OUT`: the slave drives the acknowledge.
- `ST_HOLD`: clock held low, interrupt raised.
- `ST_PREP`: data line set up before the clock is let go.
- `ST_RX`, `ST_RX_END`: shifting in a data byte and finishing it.
- `ST_TX`, `ST_TX_ACK`: shifting out a data byte and sampling the master's acknowledge.
- `ST_WAIT_STOP`: the engine stays silent until the next Start or Stop.

The transitions are:
- Start from any state goes to `ST_ADDR`. Stop from any state goes to `ST_IDLE`.
- `ST_ADDR` goes to `ST_ADDR_END` on the eighth rising clock edge.
- `ST_ADDR_END` goes to `ST_ACK_OUT` on an address match, or to `ST_WAIT_STOP` on a mismatch, at the falling clock edge.
- `ST_RX` goes to `ST_RX_END` on the eighth rising edge, then to `ST_ACK_OUT` at the falling edge.
- `ST_ACK_OUT` goes to `ST_HOLD` at the falling edge of the ninth pulse.
- `ST_HOLD` goes to `ST_PREP` on `release_i`.
- `ST_PREP` goes to `ST_TX` or `ST_RX`, depending on direction, once the data-line setup delay has run out.
- `ST_TX` goes to `ST_TX_ACK` at the falling edge of the eighth pulse.
- `ST_TX_ACK` goes to `ST_HOLD` when the master acknowledges, or to `ST_WAIT_STOP` when it does not.

Top module: `byte_stretch_slave`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `byte_irq` and `nack` are all 0.
- R2: The first byte after Start is shifted in MSB first. Bits 7..1 are the address and bit 0 is the direction (1 means the slave transmits). On a match with `OWN_ADDR` the slave pulls the data line low during the ninth pulse. On a mismatch it never pulls either line until the next Start or Stop.
- R3: In receive mode each data byte is shifted in MSB first, appears on `rx_data` after its eighth bit, and is acknowledged by pulling the data line low during the ninth pulse.
- R4: After the ninth pulse of an acknowledged address byte or received data byte, the slave holds the clock line low and raises `byte_irq`. Both stay set until `release_i`, after which both clear. `byte_irq` is never 1 while `scl_oe` is 0.
- R5: In transmit mode the byte on `tx_data` is captured at `release_i` and sent MSB first. A 0 bit is sent by pulling the data line low. The slave releases the data line for the ninth pulse.
- R6: In transmit mode, a master acknowledge (data low on the ninth pulse) leads to a clock hold with `byte_irq` for the next byte. A master non-acknowledge sets `nack`, releases both lines without a hold, and leaves the slave silent until Start or Stop.
- R7: `sda_oe` changes only while the clock line is low, and no earlier than 2 system cycles after the clock fall.
- R8: A Start or a Stop aborts any transfer and clears `scl_oe`, `sda_oe` and `byte_irq` on the next cycle. A Start, including a repeated Start in the middle of a byte, restarts address reception and clears `nack`.
- R9: `release_i` outside a clock hold has no effect: the lines stay released and a byte being received is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed clock line level |
| sda_i | input | 1 | Sensed data line level |
| scl_oe | output | 1 | Pull clock line low (stretch) |
| sda_oe | output | 1 | Pull data line low |
| byte_irq | output | 1 | Byte-complete interrupt, high while the clock is held |
| release_i | input | 1 | Host strobe: byte serviced, let the clock go |
| tx_data | input | BITS | Next byte to transmit, captured on `release_i` |
| rx_data | output | BITS | Last byte shifted in (address or data) |
| xmit | output | 1 | Direction of the current transfer, 1 = slave transmits |
| nack | output | 1 | Master declined the last transmitted byte |

## Verification
The receive path is tried with the address byte and with the data bytes 0xA5, 0x3C, 0x81 and 0x7E. These give alternating, grouped, edge-only and inner-run bit patterns, so a reversed bit order or a misplaced shift would show in the captured byte. The transmit path sends 0xC3 with a master acknowledge and then 0x5E with a non-acknowledge, which separates the hold-for-next-byte path from the give-up path. A foreign address, a release strobe in the middle of a byte and in idle, and a repeated Start after three bits check the silent, ignore and abort paths. A per-cycle monitor confirms that the data enable moves only in the clock-low phase and that the interrupt never shows without the clock hold.

// File: rtl/bss_pkg.sv
package bss_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_END,
        ST_ACK_OUT,
        ST_HOLD,
        ST_PREP,
        ST_RX,
        ST_RX_END,
        ST_TX,
        ST_TX_ACK,
        ST_WAIT_STOP
    } bss_state_e;

endpackage

// File: rtl/bss_sync.sv
module bss_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_rise,
    output logic sda_fall
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] lvl;
    logic [LINES-1:0] rise;
    logic [LINES-1:0] fall;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES:0] pipe;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe <= '1;
            end else begin
                pipe <= {pipe[STAGES-1:0], raw[g]};
            end
        end

        assign lvl[g]  = pipe[STAGES-1];
        assign rise[g] = pipe[STAGES-1] & ~pipe[STAGES];
        assign fall[g] = ~pipe[STAGES-1] & pipe[STAGES];
    end

    assign scl_s    = lvl[0];
    assign sda_s    = lvl[1];
    assign scl_rise = rise[0];
    assign scl_fall = fall[0];
    assign sda_rise = rise[1];
    assign sda_fall = fall[1];

endmodule

// File: rtl/bss_cond.sv
module bss_cond (
    input  logic scl_s,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start_det,
    output logic stop_det
);
    // data falling while clock high opens a transfer; rising while high closes it
    assign start_det = sda_fall & scl_s;
    assign stop_det  = sda_rise & scl_s;

endmodule

// File: rtl/byte_stretch_slave.sv
module byte_stretch_slave
    import bss_pkg::*;
#(
    parameter int              BITS        = 8,
    parameter logic [BITS-2:0] OWN_ADDR    = 7'h5A,
    parameter int              SYNC_STAGES = 2,
    parameter int              SETUP_DLY   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_i,
    input  logic            sda_i,
    output logic            scl_oe,
    output logic            sda_oe,
    output logic            byte_irq,
    input  logic            release_i,
    input  logic [BITS-1:0] tx_data,
    output logic [BITS-1:0] rx_data,
    output logic            xmit,
    output logic            nack
);
    localparam int            CW   = $clog2(BITS);
    localparam int            DW   = $clog2(SETUP_DLY + 1);
    localparam logic [CW-1:0] LAST = CW'(BITS - 1);
    localparam logic [DW-1:0] DLY0 = DW'(SETUP_DLY);

    bss_state_e     state, nxt;
    logic [CW-1:0]   cnt;
    logic [BITS-1:0] shreg;
    logic [DW-1:0]   dly;
    logic            sda_pend;
    logic            mack;

    logic scl_s, sda_s, scl_rise, scl_fall, sda_rise, sda_fall;
    logic start_det, stop_det, abort, addr_hit;

    bss_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sda_rise (sda_rise),
        .sda_fall (sda_fall)
    );

    bss_cond i_cond (
        .scl_s     (scl_s),
        .sda_rise  (sda_rise),
        .sda_fall  (sda_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign abort    = start_det | stop_det;
    assign addr_hit = (shreg[BITS-1:1] == OWN_ADDR);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        if (start_det) begin
            nxt = ST_ADDR;
        end else if (stop_det) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_WAIT_STOP: nxt = state;
                ST_ADDR:     if (scl_rise && cnt == LAST) nxt = ST_ADDR_END;
                ST_ADDR_END: if (scl_fall) nxt = addr_hit ? ST_ACK_OUT : ST_WAIT_STOP;
                ST_ACK_OUT:  if (scl_fall) nxt = ST_HOLD;
                ST_HOLD:     if (release_i) nxt = ST_PREP;
                ST_PREP:     if (dly == '0) nxt = xmit ? ST_TX : ST_RX;
                ST_RX:       if (scl_rise && cnt == LAST) nxt = ST_RX_END;
                ST_RX_END:   if (scl_fall) nxt = ST_ACK_OUT;
                ST_TX:       if (scl_fall && cnt == LAST) nxt = ST_TX_ACK;
                ST_TX_ACK:   if (scl_fall) nxt = mack ? ST_HOLD : ST_WAIT_STOP;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // outputs and datapath; every data-line change goes through the setup delay
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_oe   <= 1'b0;
            sda_oe   <= 1'b0;
            byte_irq <= 1'b0;
            rx_data  <= '0;
            xmit     <= 1'b0;
            nack     <= 1'b0;
            cnt      <= '0;
            shreg    <= '0;
            dly      <= '0;
            sda_pend <= 1'b0;
            mack     <= 1'b0;
        end else begin
            if (dly != '0) begin
                dly <= dly - 1'b1;
                if (dly == DW'(1)) sda_oe <= sda_pend;
            end
            if (abort) begin
                scl_oe   <= 1'b0;
                sda_oe   <= 1'b0;
                byte_irq <= 1'b0;
                dly      <= '0;
                cnt      <= '0;
                if (start_det) nack <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE, ST_WAIT_STOP: cnt <= '0;
                    ST_ADDR, ST_RX: begin
                        if (scl_rise) begin
                            shreg <= {shreg[BITS-2:0], sda_s};
                            cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
                            if (cnt == LAST) rx_data <= {shreg[BITS-2:0], sda_s};
                        end
                    end
                    ST_ADDR_END: begin
                        if (scl_fall && addr_hit) begin
                            xmit     <= shreg[0];
                            sda_pend <= 1'b1;
                            dly      <= DLY0;
                        end
                    end
                    ST_RX_END: begin
                        if (scl_fall) begin
                            sda_pend <= 1'b1;
                            dly      <= DLY0;
                        end
                    end
                    ST_ACK_OUT: begin
                        if (scl_fall) begin
                            scl_oe   <= 1'b1;
                            byte_irq <= 1'b1;
                            sda_pend <= 1'b0;
                            dly      <= DLY0;
                        end
                    end
                    ST_HOLD: begin
                        if (release_i) begin
                            byte_irq <= 1'b0;
                            cnt      <= '0;
                            dly      <= DLY0;
                            if (xmit) begin
                                shreg    <= tx_data;
                                sda_pend <= ~tx_data[BITS-1];
                            end else begin
                                sda_pend <= 1'b0;
                            end
                        end
                    end
                    ST_PREP: if (dly == '0) scl_oe <= 1'b0;
                    ST_TX: begin
                        if (scl_fall) begin
                            dly <= DLY0;
                            if (cnt == LAST) begin
                                cnt      <= '0;
                                sda_pend <= 1'b0;
                            end else begin
                                cnt      <= cnt + 1'b1;
                                shreg    <= {shreg[BITS-2:0], 1'b0};
                                sda_pend <= ~shreg[BITS-2];
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) mack <= ~sda_s;
                        if (scl_fall) begin
                            if (mack) begin
                                scl_oe   <= 1'b1;
                                byte_irq <= 1'b1;
                            end else begin
                                nack <= 1'b1;
                            end
                        end
                    end
                    default: cnt <= '0;
                endcase
            end
        end
    end

    // interrupt only ever shows during a clock hold
    assert_irq_holds_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_irq |-> scl_oe);

    // data enable moves only on a clock-low phase, aborts aside
    assert_sda_low_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((sda_oe != $past(sda_oe)) && !$past(abort)) |-> !$past(scl_s));

    // Start/Stop frees both lines and drops the interrupt
    assert_abort_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!scl_oe && !sda_oe && !byte_irq));

    // silent after a mismatch or a master NACK
    assert_quiet_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_STOP) |-> (!scl_oe && !sda_oe));

    // a NACK flag only appears at the end of a transmit frame
    assert_nack_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nack) |-> ($past(state) == ST_TX_ACK));

endmodule

// File: tb/test_byte_stretch_slave.sv
module test_byte_stretch_slave;

    localparam int HALF  = 25;
    localparam int LIMIT = 150000;
    localparam logic [6:0] ADDR = 7'h5A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       release_i = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       scl_oe, sda_oe, byte_irq, xmit, nack;
    logic [7:0] rx_data;
    logic       scl_line, sda_line;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #10 clk = ~clk;

    assign scl_line = scl_m & ~scl_oe;
    assign sda_line = sda_m & ~sda_oe;

    byte_stretch_slave i_byte_stretch_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_line),
        .sda_i     (sda_line),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .byte_irq  (byte_irq),
        .release_i (release_i),
        .tx_data   (tx_data),
        .rx_data   (rx_data),
        .xmit      (xmit),
        .nack      (nack)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    // per-cycle reference checks: data enable timing and hold/interrupt pairing
    logic prev_oe = 1'b0;
    logic prev_scl = 1'b1;
    int   lowcnt = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (sda_oe != prev_oe)
                chk(!prev_scl && lowcnt >= 2, "R7 data enable moved outside clock-low", lowcnt, 2);
            chk(!byte_irq || scl_oe, "R4 irq without clock hold", {byte_irq, scl_oe}, 3);
        end
        prev_oe  = sda_oe;
        prev_scl = scl_line;
        lowcnt   = scl_line ? 0 : lowcnt + 1;
    end

    task automatic pulse(input bit b, output bit seen, output bit oe_hi);
        sda_m = b;
        wt(HALF);
        scl_m = 1'b1;
        @(negedge clk);
        while (!scl_line) @(negedge clk);
        wt(HALF / 2);
        seen  = sda_line;
        oe_hi = sda_oe;
        wt(HALF / 2);
        scl_m = 1'b0;
        wt(HALF);
    endtask

    task automatic start_cond();
        sda_m = 1'b1; wt(HALF);
        scl_m = 1'b1; wt(HALF);
        sda_m = 1'b0; wt(HALF);
        scl_m = 1'b0; wt(HALF);
    endtask

    task automatic stop_cond();
        sda_m = 1'b0; wt(HALF);
        scl_m = 1'b1; wt(HALF);
        sda_m = 1'b1; wt(HALF);
    endtask

    task automatic host_release();
        @(negedge clk) release_i = 1'b1;
        @(negedge clk) release_i = 1'b0;
        wt(10);
    endtask

    task automatic send_byte(input logic [7:0] b, input int poke, output bit ack);
        bit s, o;
        for (int i = 7; i >= 0; i--) begin
            pulse(b[i], s, o);
            if (i == poke) host_release();
        end
        pulse(1'b1, s, o);
        ack = !s;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b, output bit oe9);
        bit s, o;
        for (int i = 7; i >= 0; i--) begin
            pulse(1'b1, s, o);
            b[i] = s;
        end
        pulse(!mack, s, oe9);
    endtask

    task automatic chk_hold(input string tag);
        chk(scl_oe && byte_irq, tag, {scl_oe, byte_irq}, 3);
    endtask

    task automatic chk_free(input string tag);
        chk(!scl_oe && !sda_oe && !byte_irq, tag, {scl_oe, sda_oe, byte_irq}, 0);
    endtask

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", LIMIT, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] wq[$];
        logic [7:0] tq[$];
        logic [7:0] got;
        bit ack, oe9;

        wt(5);
        rst_n = 1'b1;
        wt(5);
        // R1: reset state
        chk(!scl_oe && !sda_oe && !byte_irq && !nack, "R1 reset outputs",
            {scl_oe, sda_oe, byte_irq, nack}, 0);

        // R9: release strobe in idle does nothing
        host_release();
        chk_free("R9 idle release");

        // ---- receive transfer ----
        wq = '{8'hA5, 8'h3C, 8'h81};
        start_cond();
        send_byte({ADDR, 1'b0}, -1, ack);
        chk(ack, "R2 own address acked", ack, 1);
        wt(HALF);
        chk_hold("R4 hold after address");
        chk(rx_data == {ADDR, 1'b0}, "R2 address byte captured", rx_data, {ADDR, 1'b0});
        chk(!xmit, "R2 direction write", xmit, 0);
        host_release();
        chk_free("R4 released after strobe");
        while (wq.size() > 0) begin
            automatic logic [7:0] b = wq.pop_front();
            send_byte(b, (b == 8'h3C) ? 4 : -1, ack);
            chk(ack, "R3 data byte acked", ack, 1);
            wt(HALF);
            chk_hold("R4 hold after data byte");
            chk(rx_data == b, "R3 R9 received byte", rx_data, b);
            host_release();
            chk_free("R4 released after data");
        end
        stop_cond();
        wt(10);
        chk_free("R8 stop leaves lines free");

        // ---- transmit transfer ----
        tq = '{8'hC3, 8'h5E};
        start_cond();
        send_byte({ADDR, 1'b1}, -1, ack);
        chk(ack, "R2 read address acked", ack, 1);
        wt(HALF);
        chk_hold("R4 hold before first transmit byte");
        chk(xmit, "R2 direction read", xmit, 1);
        tx_data = tq[0];
        host_release();
        recv_byte(1'b1, got, oe9);
        chk(got == tq[0], "R5 transmitted byte", got, tq[0]);
        chk(!oe9, "R5 data line released on ninth pulse", oe9, 0);
        wt(HALF);
        chk_hold("R6 hold after master ack");
        tx_data = tq[1];
        host_release();
        recv_byte(1'b0, got, oe9);
        chk(got == tq[1], "R5 second transmitted byte", got, tq[1]);
        wt(HALF);
        chk(nack, "R6 nack flag", nack, 1);
        chk_free("R6 no hold after nack");
        stop_cond();
        wt(10);
        chk_free("R8 stop after nack");

        // ---- foreign address ----
        start_cond();
        chk(!nack, "R8 start clears nack", nack, 0);
        send_byte({7'h33, 1'b0}, -1, ack);
        chk(!ack, "R2 foreign address not acked", ack, 0);
        wt(HALF);
        chk_free("R2 silent after mismatch");
        send_byte(8'h00, -1, ack);
        chk(!ack, "R2 still silent", ack, 0);
        stop_cond();

        // ---- repeated start mid-byte ----
        start_cond();
        send_byte({ADDR, 1'b0}, -1, ack);
        chk(ack, "R2 address before abort", ack, 1);
        wt(HALF);
        host_release();
        begin
            bit s, o;
            pulse(1'b1, s, o);
            pulse(1'b0, s, o);
            pulse(1'b1, s, o);
        end
        start_cond();
        wt(2);
        chk_free("R8 repeated start aborts");
        send_byte({ADDR, 1'b0}, -1, ack);
        chk(ack, "R8 address after repeated start", ack, 1);
        wt(HALF);
        host_release();
        send_byte(8'h7E, -1, ack);
        wt(HALF);
        chk(ack && rx_data == 8'h7E, "R3 byte after repeated start", rx_data, 8'h7E);
        host_release();
        stop_cond();
        wt(10);
        chk_free("R8 final stop");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule